// File: doc/BRIEF.md
# Tag Store with Lookup Comparator

This block keeps the tag half of a direct-mapped cache directory. Every entry holds a tag word and two status flags, a valid flag and a dirty flag. One address input selects the entry. A comparator checks the stored tag at that entry against the tag presented on the input pins and drives a hit output. The read-back path and the compare path are both combinational. They follow the address and tag inputs without waiting for a clock.

Writes of the tag and both flags happen on the rising clock edge. A write needs the block to be selected, awake and out of reset. An active-low asynchronous reset clears the status flags of every entry at once, which invalidates the whole directory. Stored tags are left as they are. A qualify input chooses whether a hit also needs the valid flag. The dirty flag is only stored and returned, and it never affects a hit.

The block is selected only when both chip selects are active. The depth is a parameter with a default of 2048 entries. It can be set up to 8192 entries, which gives a 13-bit index. The address width follows from the depth, which must be a power of two.

Top module: `tag_match_store`

## Requirements
- R1: On a rising clock edge with `writeEn`=1, `cs1N`=0, `cs2`=1, `sleep`=0 and `rstN`=1, the entry at `addr` takes `tagIn`, `validIn` and `dirtyIn`. The read-back of that entry shows the new values right after that edge.
- R2: With `validQual`=0, `match` is 1 exactly when the stored tag at `addr` equals `tagIn`, whatever the valid flag holds.
- R3: With `validQual`=1, `match` is 1 only if the tags are equal and the stored valid flag is 1.
- R4: The dirty flag has no effect on `match`. A hit occurs with the dirty flag at either 0 or 1.
- R5: While `rstN` is 0, every entry reads back valid=0 and dirty=0, with no clock edge needed. Stored tags survive reset, so a tag compare with `validQual`=0 still hits after reset.
- R6: If `rstN` is 0 at a clock edge where a write is requested, reset wins and the write is dropped.
- R7: The block is selected only when `cs1N`=0 and `cs2`=1. While it is deselected, writes are ignored and `match` is 0.
- R8: While `sleep`=1, writes are ignored and `match` is 0.
- R9: While `outEn`=0, `tagOut`, `validOut` and `dirtyOut` read 0 and `match` is unaffected. Read-back is also 0 while the block is deselected or asleep.
- R10: `match` and the read-back outputs change within the same cycle when `addr` or `tagIn` change, with no clock edge in between.
- R11: While `rstN` is 0, `match` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rstN | input | 1 | Asynchronous active-low flash invalidate |
| cs1N | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| sleep | input | 1 | Low-power request; blocks writes and hits |
| writeEn | input | 1 | Write request, sampled at the clock edge |
| outEn | input | 1 | Enables the read-back outputs |
| validQual | input | 1 | 1: a hit also requires the valid flag |
| addr | input | ADDR_W | Entry index |
| tagIn | input | TAG_W | Tag to write and to compare |
| validIn | input | 1 | Valid flag to write |
| dirtyIn | input | 1 | Dirty flag to write |
| tagOut | output | TAG_W | Stored tag at `addr`, gated |
| validOut | output | 1 | Stored valid flag at `addr`, gated |
| dirtyOut | output | 1 | Stored dirty flag at `addr`, gated |
| match | output | 1 | Hit indication |

## Verification
Each entry's state shows up at the ports within the same cycle: the combinational read-back and `match` reflect a stored tag or flag as soon as the entry is addressed. A write that landed in the wrong entry, or one let through while deselected, asleep or in reset, therefore appears on the next read of either entry as a wrong tag or flag, or as a wrong hit. A flag that escapes the flash clear shows up as a nonzero `validOut` or `dirtyOut` while reset is still held. It also shows up as a hit under `validQual`=1 after reset.

// File: rtl/tms_pkg.sv
package tms_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic wrStrobe;    // commit a write at the next rising edge
    logic cmpEnable;   // comparator result may reach the hit output
    logic readEnable;  // stored values may reach the read-back outputs
  } tmsStrobe_t;

endpackage

// File: rtl/tms_ctrl.sv
module tms_ctrl
  import tms_pkg::*;
(
  input  logic       rstN,
  input  logic       cs1N,
  input  logic       cs2,
  input  logic       sleep,
  input  logic       writeEn,
  input  logic       outEn,
  output tmsStrobe_t strobe
);

  logic selected;
  logic awake;
  logic live;

  // Both selects must agree; sleep overrides everything.
  assign selected = !cs1N && cs2;
  assign awake    = !sleep;
  // Reset holds the block out of operation: no write, no hit.
  assign live     = selected && awake && rstN;

  always_comb begin
    strobe            = '0;
    strobe.wrStrobe   = live && writeEn;
    strobe.cmpEnable  = live;
    strobe.readEnable = selected && awake && outEn;
  end

endmodule

// File: rtl/tms_datapath.sv
module tms_datapath
  import tms_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int TAG_W  = 14,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmsStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic              validIn,
  input  logic              dirtyIn,
  input  logic              validQual,
  output logic [TAG_W-1:0]  tagOut,
  output logic              validOut,
  output logic              dirtyOut,
  output logic              match
);

  // Tags sit in a plain array (no reset); the flags are flops so one
  // reset can clear them all together.
  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [DEPTH-1:0] validBits;
  logic [DEPTH-1:0] dirtyBits;
  logic [DEPTH-1:0] wrSel;

  logic [TAG_W-1:0] storedTag;
  logic             storedValid;
  logic             storedDirty;
  logic             tagEqual;
  logic             hitRaw;

  // One-hot entry decode for the flag write.
  always_comb begin
    wrSel = '0;
    if (strobe.wrStrobe) wrSel[addr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrStrobe) tagMem[addr] <= tagIn;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flags
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validBits[i] <= 1'b0;
        dirtyBits[i] <= 1'b0;
      end else if (wrSel[i]) begin
        validBits[i] <= validIn;
        dirtyBits[i] <= dirtyIn;
      end
    end
  end

  // Combinational read and compare.
  assign storedTag   = tagMem[addr];
  assign storedValid = validBits[addr];
  assign storedDirty = dirtyBits[addr];
  assign tagEqual    = (storedTag == tagIn);
  // The dirty flag is deliberately absent from the hit term.
  assign hitRaw      = tagEqual && (!validQual || storedValid);

  assign match    = strobe.cmpEnable && hitRaw;
  assign tagOut   = strobe.readEnable ? storedTag : '0;
  assign validOut = strobe.readEnable && storedValid;
  assign dirtyOut = strobe.readEnable && storedDirty;

  // R1: a committed write is visible in the entry on the next edge.
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.wrStrobe) |-> (tagMem[$past(addr)] == $past(tagIn)) &&
                               (validBits[$past(addr)] == $past(validIn)) &&
                               (dirtyBits[$past(addr)] == $past(dirtyIn)));

  // R3: a qualified hit implies the addressed entry is valid.
  assert_qual_needs_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (match && validQual) |-> validBits[addr]);

  // R5: leaving reset, no entry holds a set flag.
  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (validBits == '0) && (dirtyBits == '0));

endmodule

// File: rtl/tag_match_store.sv
module tag_match_store
  import tms_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int TAG_W  = 14,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs1N,
  input  logic              cs2,
  input  logic              sleep,
  input  logic              writeEn,
  input  logic              outEn,
  input  logic              validQual,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic              validIn,
  input  logic              dirtyIn,
  output logic [TAG_W-1:0]  tagOut,
  output logic              validOut,
  output logic              dirtyOut,
  output logic              match
);

  tmsStrobe_t strobe;

  tms_ctrl u_ctrl (
    .rstN    (rstN),
    .cs1N    (cs1N),
    .cs2     (cs2),
    .sleep   (sleep),
    .writeEn (writeEn),
    .outEn   (outEn),
    .strobe  (strobe)
  );

  tms_datapath #(
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W),
    .ADDR_W (ADDR_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (addr),
    .tagIn     (tagIn),
    .validIn   (validIn),
    .dirtyIn   (dirtyIn),
    .validQual (validQual),
    .tagOut    (tagOut),
    .validOut  (validOut),
    .dirtyOut  (dirtyOut),
    .match     (match)
  );

  // R7: no hit while either select is inactive.
  assert_deselect_nomatch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cs1N || !cs2) |-> !match);

  // R8: no hit while asleep.
  assert_sleep_nomatch_R8: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !match);

  // R9: read-back is zero with the output enable low.
  assert_oe_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (tagOut == '0) && !validOut && !dirtyOut);

endmodule

// File: tb/tag_match_store_bench.sv
`timescale 1ns/100ps
module tag_match_store_bench;

  localparam int DEPTH  = 64;
  localparam int TAG_W  = 14;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cs1N = 1'b1;
  logic              cs2 = 1'b0;
  logic              sleep = 1'b0;
  logic              writeEn = 1'b0;
  logic              outEn = 1'b0;
  logic              validQual = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [TAG_W-1:0]  tagIn = '0;
  logic              validIn = 1'b0;
  logic              dirtyIn = 1'b0;
  logic [TAG_W-1:0]  tagOut;
  logic              validOut;
  logic              dirtyOut;
  logic              match;

  always #2 clk = ~clk;  // 250 MHz

  tag_match_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tag_match_store (
    .clk(clk), .rstN(rstN), .cs1N(cs1N), .cs2(cs2), .sleep(sleep),
    .writeEn(writeEn), .outEn(outEn), .validQual(validQual), .addr(addr),
    .tagIn(tagIn), .validIn(validIn), .dirtyIn(dirtyIn), .tagOut(tagOut),
    .validOut(validOut), .dirtyOut(dirtyOut), .match(match)
  );

  typedef struct {
    string            req;
    logic             chkM;
    logic             expM;
    logic             chkT;
    logic [TAG_W-1:0] expT;
    logic             expV;
    logic             expD;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model of the directory.
  logic [TAG_W-1:0] tagModel [DEPTH];
  logic [DEPTH-1:0] validModel = '0;
  logic [DEPTH-1:0] dirtyModel = '0;
  logic [DEPTH-1:0] tagKnown = '0;

  task automatic cmp1(input string req, input string what,
                      input logic [TAG_W-1:0] act, input logic [TAG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus, expected outputs pushed to the queue.
  task automatic cycle(input string req, input logic c1n, input logic c2,
                       input logic slp, input logic rst, input logic we,
                       input int a, input logic [TAG_W-1:0] t,
                       input logic v, input logic d, input logic vq, input logic oe);
    item_t it;
    logic active, rdEn;
    @(negedge clk);
    cs1N = c1n; cs2 = c2; sleep = slp; rstN = rst; writeEn = we;
    addr = ADDR_W'(a); tagIn = t; validIn = v; dirtyIn = d;
    validQual = vq; outEn = oe;
    if (!rst) begin
      validModel = '0;
      dirtyModel = '0;
    end
    active = !c1n && c2 && !slp && rst;
    rdEn   = !c1n && c2 && !slp && oe;
    it.req  = req;
    it.chkM = !active || tagKnown[a];
    it.expM = active && tagKnown[a] && (tagModel[a] == t) && (!vq || validModel[a]);
    it.chkT = !rdEn || tagKnown[a];
    it.expT = rdEn ? tagModel[a] : '0;
    it.expV = rdEn && validModel[a];
    it.expD = rdEn && dirtyModel[a];
    q.push_back(it);
    if (active && we) begin
      tagModel[a]   = t;
      validModel[a] = v;
      dirtyModel[a] = d;
      tagKnown[a]   = 1'b1;
    end
  endtask

  // Monitor: compares outputs 1 ns after the stimulus settles.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chkM) cmp1(it.req, "match", TAG_W'(match), TAG_W'(it.expM));
        if (it.chkT) cmp1(it.req, "tagOut", tagOut, it.expT);
        cmp1(it.req, "validOut", TAG_W'(validOut), TAG_W'(it.expV));
        cmp1(it.req, "dirtyOut", TAG_W'(dirtyOut), TAG_W'(it.expD));
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11, R6: reset held, write requested, no hit.
    cycle("R11", 0, 1, 0, 0, 1, 5, 14'h1A2B, 1, 1, 0, 1);
    cycle("R6",  0, 1, 0, 0, 1, 5, 14'h1A2B, 1, 1, 0, 1);
    // R1: writes.
    cycle("R1", 0, 1, 0, 1, 1, 5,  14'h1A2B, 1, 0, 0, 1);
    cycle("R1", 0, 1, 0, 1, 1, 9,  14'h3FFF, 0, 1, 0, 1);
    cycle("R1", 0, 1, 0, 1, 1, 63, 14'h0000, 1, 1, 0, 1);
    cycle("R1", 0, 1, 0, 1, 1, 0,  14'h0155, 0, 0, 0, 1);
    // R1, R2, R3, R4, R10: combinational reads and compares.
    cycle("R1",  0, 1, 0, 1, 0, 5,  14'h1A2B, 0, 0, 0, 1);
    cycle("R3",  0, 1, 0, 1, 0, 5,  14'h1A2B, 0, 0, 1, 1);
    cycle("R2",  0, 1, 0, 1, 0, 9,  14'h3FFF, 0, 0, 0, 1);
    cycle("R3",  0, 1, 0, 1, 0, 9,  14'h3FFF, 0, 0, 1, 1);
    cycle("R2",  0, 1, 0, 1, 0, 5,  14'h1A2A, 0, 0, 0, 1);
    cycle("R4",  0, 1, 0, 1, 0, 63, 14'h0000, 0, 0, 1, 1);
    cycle("R4",  0, 1, 0, 1, 0, 0,  14'h0155, 0, 0, 0, 1);
    cycle("R10", 0, 1, 0, 1, 0, 9,  14'h0155, 0, 0, 0, 1);
    // R9: outputs gated, hit kept.
    cycle("R9", 0, 1, 0, 1, 0, 5, 14'h1A2B, 0, 0, 1, 0);
    // R7: write blocked by either select.
    cycle("R7", 1, 1, 0, 1, 1, 5, 14'h2AAA, 0, 1, 0, 1);
    cycle("R7", 0, 1, 0, 1, 0, 5, 14'h1A2B, 0, 0, 1, 1);
    cycle("R7", 0, 0, 0, 1, 1, 9, 14'h0000, 1, 0, 0, 1);
    cycle("R7", 0, 1, 0, 1, 0, 9, 14'h3FFF, 0, 0, 0, 1);
    // R8: sleep blocks writes and hits.
    cycle("R8", 0, 1, 1, 1, 1, 63, 14'h1111, 0, 0, 0, 1);
    cycle("R8", 0, 1, 1, 1, 0, 5,  14'h1A2B, 0, 0, 0, 1);
    cycle("R8", 0, 1, 0, 1, 0, 63, 14'h0000, 0, 0, 1, 1);
    // R6, R5: reset wins over write; flags cleared, tags kept.
    cycle("R6", 0, 1, 0, 0, 1, 9,  14'h0123, 1, 1, 0, 1);
    cycle("R5", 0, 1, 0, 0, 0, 63, 14'h0000, 0, 0, 0, 1);
    cycle("R5", 0, 1, 0, 1, 0, 9,  14'h3FFF, 0, 0, 0, 1);
    cycle("R5", 0, 1, 0, 1, 0, 9,  14'h3FFF, 0, 0, 1, 1);
    cycle("R5", 0, 1, 0, 1, 0, 5,  14'h1A2B, 0, 0, 1, 1);
    // R1 after reset.
    cycle("R1", 0, 1, 0, 1, 1, 63, 14'h0ABC, 1, 0, 0, 1);
    cycle("R1", 0, 1, 0, 1, 0, 63, 14'h0ABC, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule